// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Walker

This block reads one transmit frame descriptor from a neighbouring descriptor memory and turns it into an ordered stream of buffer fetch requests. Each request carries an address and a length. Together the requests gather the pieces of a single outgoing frame. A descriptor is 128 bytes long and is stored little-endian in 32-bit words. It holds a buffer count followed by as many as twenty packed buffer entries. Each entry is six bytes: a 32-bit low address word, then a 16-bit word that holds the top four address bits and a 12-bit length.

After a start pulse, the walker fetches the header word and checks the count. It then fetches the descriptor words strictly in ascending order, one word per fetch cycle. Because the entries are six bytes wide, every second entry straddles two memory words. The walker reassembles each entry and checks it against a per-buffer length cap and a whole-frame length cap. Each legal entry is offered as a request on a valid/ready handshake. When the last request is accepted, the walker emits a done pulse that carries the total frame length. An illegal count, an overlong buffer or an overlong frame ends the walk with an error pulse and a cause code.

Top module: `txw_desc_walker`

## Requirements
- R1: A start pulse is acted on only while busy_o is low. busy_o is high from the cycle after an accepted start through the cycle of the done or error pulse. A start pulse that arrives while busy_o is high does not begin a second walk.
- R2: The buffer count is taken from bits 4:0 of descriptor byte 3 (word 0 bits 28:24). Bits 7:5 of that byte and bytes 0 to 2 have no effect on the walk.
- R3: A count of 0, or a count above 20, produces an error pulse with err_code_o = 1 and no request at all.
- R4: Entry i starts at byte offset 4+6i. Its first four bytes are address bits 31:0, little-endian. The 16-bit word that follows holds address bits 35:32 in bits 3:0 and the length in bits 15:4. Requests appear in index order with req_idx_o = i, and req_last_o is high only on entry count-1.
- R5: While req_valid_o is high and req_ready_i is low, the request and its fields hold steady. The next request appears only after the current one has been accepted.
- R6: A buffer whose length is above 4092 produces an error pulse with err_code_o = 2. No request is issued for that buffer or for any later one; all earlier buffers have already been requested. A length of exactly 4092 is legal.
- R7: If adding a buffer would lift the running total above 8192 bytes, the walk ends with err_code_o = 3 and no request for that buffer. A total of exactly 8192 is legal.
- R8: done_o pulses for exactly one cycle, in the cycle right after the last request is accepted. frame_len_o then equals the sum of all requested lengths.
- R9: done_o and err_o are never high together, and err_code_o is 0 whenever err_o is low. busy_o is low in the cycle after a done or error pulse.
- R10: After reset, busy_o, req_valid_o, mem_rd_o, done_o and err_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin walking the descriptor |
| busy_o | output | 1 | A walk is in progress |
| mem_rd_o | output | 1 | Descriptor memory read strobe |
| mem_addr_o | output | 5 | Descriptor word index to read |
| mem_data_i | input | 32 | Read word, valid the cycle after the strobe |
| req_valid_o | output | 1 | Buffer request is offered |
| req_ready_i | input | 1 | Consumer accepts the offered request |
| req_addr_o | output | 36 | Buffer byte address |
| req_len_o | output | 12 | Buffer length in bytes |
| req_idx_o | output | 5 | Buffer index within the descriptor |
| req_last_o | output | 1 | Offered request is the final buffer |
| done_o | output | 1 | One-cycle completion pulse |
| frame_len_o | output | 14 | Total frame length, meaningful with done_o |
| err_o | output | 1 | One-cycle error pulse |
| err_code_o | output | 2 | Cause: 1 bad count, 2 buffer too long, 3 frame too long |

## Verification
The bound checker watches several properties on every cycle:
- requests stay stable under backpressure;
- no offered length exceeds the buffer cap;
- done follows the final acceptance by exactly one cycle and respects the frame cap;
- done and error stay mutually exclusive;
- no request or memory read happens while the block is idle.

Other behaviours only the bench scenarios can show, because they need the descriptor image:
- that the byte layout is decoded correctly, including the entries that straddle two words;
- that the reserved count bits are ignored;
- that the summed frame length is correct;
- that an error stops the walk at the right buffer index.

The bench covers these by sweeping every possible count value under three backpressure patterns, then driving the length boundaries at 4092/4093 per buffer and 8192/8193 per frame.

// File: rtl/txw_pkg.sv
package txw_pkg;

    localparam int WORD_W  = 32;
    localparam int ADDR_W  = 36;
    localparam int HI_W    = 4;
    localparam int LEN_W   = 12;
    localparam int CNT_W   = 5;
    localparam int CNT_LSB = 24;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } txw_entry_t;

    typedef enum logic [1:0] {
        TXW_OK         = 2'd0,
        TXW_BAD_COUNT  = 2'd1,
        TXW_BUF_LONG   = 2'd2,
        TXW_FRAME_LONG = 2'd3
    } txw_err_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR,
        S_LO,
        S_HI,
        S_ODD,
        S_REQ,
        S_FIN,
        S_ERR
    } txw_state_e;

    // Even entries: low word is word "first", tail half-word is the low half of "second".
    // Odd entries: the low address straddles the upper half of "first" and the lower half
    // of "second"; the tail half-word is the upper half of "second".
    function automatic txw_entry_t txw_unpack(input logic [WORD_W-1:0] first,
                                              input logic [WORD_W-1:0] second,
                                              input logic              odd);
        txw_entry_t       e;
        logic [WORD_W-1:0] lo;
        logic [15:0]       tail;
        if (odd) begin
            lo   = {second[15:0], first[31:16]};
            tail = second[31:16];
        end else begin
            lo   = first;
            tail = second[15:0];
        end
        e.addr = {tail[HI_W-1:0], lo};
        e.len  = tail[15:HI_W];
        return e;
    endfunction

endpackage

// File: rtl/txw_entry_unpack.sv
module txw_entry_unpack
    import txw_pkg::*;
(
    input  logic [WORD_W-1:0] first_i,
    input  logic [WORD_W-1:0] second_i,
    input  logic              odd_i,
    output txw_entry_t        entry_o
);

    always_comb begin
        entry_o = txw_unpack(first_i, second_i, odd_i);
    end

endmodule

// File: rtl/txw_len_guard.sv
module txw_len_guard
    import txw_pkg::*;
#(
    parameter int BUF_MAX   = 4092,
    parameter int FRAME_MAX = 8192,
    parameter int TOT_W     = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  logic             commit_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [TOT_W-1:0] total_o,
    output logic             buf_bad_o,
    output logic             frame_bad_o
);

    logic [TOT_W-1:0] total_q;
    logic [TOT_W-1:0] sum;

    always_comb begin
        sum         = total_q + TOT_W'(len_i);
        buf_bad_o   = (int'(len_i) > BUF_MAX);
        frame_bad_o = (int'(sum) > FRAME_MAX);
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            total_q <= '0;
        end else if (commit_i) begin
            total_q <= sum;
        end
    end

    assign total_o = total_q;

endmodule

// File: rtl/txw_seq.sv
module txw_seq
    import txw_pkg::*;
#(
    parameter int MAX_BUFS = 20,
    parameter int MEM_AW   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] mem_data_i,
    input  txw_entry_t        entry_i,
    input  logic              buf_bad_i,
    input  logic              frame_bad_i,
    input  logic              req_ready_i,
    output logic              mem_rd_o,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic [WORD_W-1:0] prev_o,
    output logic              odd_o,
    output logic              clear_o,
    output logic              commit_o,
    output logic              busy_o,
    output logic              req_valid_o,
    output txw_entry_t        req_o,
    output logic [CNT_W-1:0]  req_idx_o,
    output logic              req_last_o,
    output logic              done_o,
    output logic              err_o,
    output logic [1:0]        err_code_o
);

    txw_state_e        state_q, state_d;
    logic [MEM_AW-1:0] wptr_q;
    logic [WORD_W-1:0] prev_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  idx_q;
    txw_entry_t        req_q;
    txw_err_e          err_q, err_d;
    logic [CNT_W-1:0]  hdr_cnt;
    logic              last;

    assign hdr_cnt = mem_data_i[CNT_LSB +: CNT_W];
    assign last    = ((idx_q + CNT_W'(1)) == cnt_q);

    always_comb begin
        state_d    = state_q;
        err_d      = err_q;
        mem_rd_o   = 1'b0;
        mem_addr_o = wptr_q;
        clear_o    = 1'b0;
        commit_o   = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    mem_rd_o   = 1'b1;
                    mem_addr_o = '0;
                    clear_o    = 1'b1;
                    state_d    = S_HDR;
                end
            end
            S_HDR: begin
                if (hdr_cnt == '0 || int'(hdr_cnt) > MAX_BUFS) begin
                    err_d   = TXW_BAD_COUNT;
                    state_d = S_ERR;
                end else begin
                    mem_rd_o = 1'b1;
                    state_d  = S_LO;
                end
            end
            S_LO: begin
                mem_rd_o = 1'b1;
                state_d  = S_HI;
            end
            S_HI, S_ODD: begin
                if (buf_bad_i) begin
                    err_d   = TXW_BUF_LONG;
                    state_d = S_ERR;
                end else if (frame_bad_i) begin
                    err_d   = TXW_FRAME_LONG;
                    state_d = S_ERR;
                end else begin
                    commit_o = 1'b1;
                    state_d  = S_REQ;
                end
            end
            S_REQ: begin
                if (req_ready_i) begin
                    if (last) begin
                        state_d = S_FIN;
                    end else begin
                        mem_rd_o = 1'b1;
                        state_d  = idx_q[0] ? S_LO : S_ODD;
                    end
                end
            end
            S_FIN, S_ERR: state_d = S_IDLE;
            default:      state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            wptr_q  <= '0;
            prev_q  <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            req_q   <= '0;
            err_q   <= TXW_OK;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            if (clear_o) begin
                wptr_q <= MEM_AW'(1);
                idx_q  <= '0;
                err_q  <= TXW_OK;
            end else if (mem_rd_o) begin
                wptr_q <= wptr_q + MEM_AW'(1);
            end
            if (state_q == S_HDR) begin
                cnt_q <= hdr_cnt;
            end
            if (state_q == S_LO || state_q == S_HI) begin
                prev_q <= mem_data_i;
            end
            if (commit_o) begin
                req_q <= entry_i;
            end
            if (state_q == S_REQ && req_ready_i) begin
                idx_q <= idx_q + CNT_W'(1);
            end
        end
    end

    assign prev_o      = prev_q;
    assign odd_o       = (state_q == S_ODD);
    assign busy_o      = (state_q != S_IDLE);
    assign req_valid_o = (state_q == S_REQ);
    assign req_o       = req_q;
    assign req_idx_o   = idx_q;
    assign req_last_o  = (state_q == S_REQ) && last;
    assign done_o      = (state_q == S_FIN);
    assign err_o       = (state_q == S_ERR);
    assign err_code_o  = (state_q == S_ERR) ? err_q : TXW_OK;

endmodule

// File: rtl/txw_desc_walker.sv
module txw_desc_walker
    import txw_pkg::*;
#(
    parameter int MAX_BUFS   = 20,
    parameter int BUF_MAX    = 4092,
    parameter int FRAME_MAX  = 8192,
    parameter int DESC_BYTES = 128
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic                                           start_i,
    output logic                                           busy_o,
    output logic                                           mem_rd_o,
    output logic [$clog2(DESC_BYTES/4)-1:0]                mem_addr_o,
    input  logic [31:0]                                    mem_data_i,
    output logic                                           req_valid_o,
    input  logic                                           req_ready_i,
    output logic [35:0]                                    req_addr_o,
    output logic [11:0]                                    req_len_o,
    output logic [4:0]                                     req_idx_o,
    output logic                                           req_last_o,
    output logic                                           done_o,
    output logic [$clog2(FRAME_MAX + (1 << 12))-1:0]       frame_len_o,
    output logic                                           err_o,
    output logic [1:0]                                     err_code_o
);

    localparam int MEM_AW = $clog2(DESC_BYTES / 4);
    localparam int TOT_W  = $clog2(FRAME_MAX + (1 << LEN_W));

    txw_entry_t        entry;
    txw_entry_t        req;
    logic [WORD_W-1:0] prev;
    logic              odd;
    logic              clear;
    logic              commit;
    logic              buf_bad;
    logic              frame_bad;

    txw_entry_unpack u_unpack (
        .first_i  (prev),
        .second_i (mem_data_i),
        .odd_i    (odd),
        .entry_o  (entry)
    );

    txw_len_guard #(
        .BUF_MAX   (BUF_MAX),
        .FRAME_MAX (FRAME_MAX),
        .TOT_W     (TOT_W)
    ) u_guard (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (clear),
        .commit_i    (commit),
        .len_i       (entry.len),
        .total_o     (frame_len_o),
        .buf_bad_o   (buf_bad),
        .frame_bad_o (frame_bad)
    );

    txw_seq #(
        .MAX_BUFS (MAX_BUFS),
        .MEM_AW   (MEM_AW)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .mem_data_i  (mem_data_i),
        .entry_i     (entry),
        .buf_bad_i   (buf_bad),
        .frame_bad_i (frame_bad),
        .req_ready_i (req_ready_i),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .prev_o      (prev),
        .odd_o       (odd),
        .clear_o     (clear),
        .commit_o    (commit),
        .busy_o      (busy_o),
        .req_valid_o (req_valid_o),
        .req_o       (req),
        .req_idx_o   (req_idx_o),
        .req_last_o  (req_last_o),
        .done_o      (done_o),
        .err_o       (err_o),
        .err_code_o  (err_code_o)
    );

    assign req_addr_o = req.addr;
    assign req_len_o  = req.len;

endmodule

// File: rtl/txw_desc_walker_chk.sv
module txw_desc_walker_chk #(
    parameter int BUF_MAX   = 4092,
    parameter int FRAME_MAX = 8192,
    parameter int TOT_W     = 14
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             busy_o,
    input logic             mem_rd_o,
    input logic             req_valid_o,
    input logic             req_ready_i,
    input logic [35:0]      req_addr_o,
    input logic [11:0]      req_len_o,
    input logic [4:0]       req_idx_o,
    input logic             req_last_o,
    input logic             done_o,
    input logic [TOT_W-1:0] frame_len_o,
    input logic             err_o,
    input logic [1:0]       err_code_o
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!req_valid_o && !done_o && !err_o && (mem_rd_o == start_i)));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !req_ready_i) |=>
            (req_valid_o && $stable(req_addr_o) && $stable(req_len_o) && $stable(req_idx_o)));

    a_r5_one_per_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && req_ready_i) |=> !req_valid_o);

    a_r6_len_cap: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> (int'(req_len_o) <= BUF_MAX));

    a_r7_frame_cap: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (int'(frame_len_o) <= FRAME_MAX));

    a_r8_done_follows_last: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && req_ready_i && req_last_o) |=> done_o);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

    a_r9_code_quiet: assert property (@(posedge clk) disable iff (rst)
        (err_o |-> (err_code_o != 2'd0)) and (!err_o |-> (err_code_o == 2'd0)));

    a_r9_return_idle: assert property (@(posedge clk) disable iff (rst)
        (done_o || err_o) |=> !busy_o);

endmodule

bind txw_desc_walker txw_desc_walker_chk #(
    .BUF_MAX   (BUF_MAX),
    .FRAME_MAX (FRAME_MAX),
    .TOT_W     (TOT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .mem_rd_o    (mem_rd_o),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_addr_o  (req_addr_o),
    .req_len_o   (req_len_o),
    .req_idx_o   (req_idx_o),
    .req_last_o  (req_last_o),
    .done_o      (done_o),
    .frame_len_o (frame_len_o),
    .err_o       (err_o),
    .err_code_o  (err_code_o)
);

// File: tb/txw_desc_walker_bench.sv
module txw_desc_walker_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NBUF       = 20;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        busy;
    logic        mem_rd;
    logic [4:0]  mem_addr;
    logic [31:0] mem_data;
    logic        req_valid;
    logic        req_ready;
    logic [35:0] req_addr;
    logic [11:0] req_len;
    logic [4:0]  req_idx;
    logic        req_last;
    logic        done;
    logic [13:0] frame_len;
    logic        err;
    logic [1:0]  err_code;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0]  dbytes [128];
    logic [35:0] exp_addr [NBUF];
    logic [11:0] exp_len [NBUF];

    always #(CLK_PERIOD / 2) clk = ~clk;

    txw_desc_walker u_txw_desc_walker (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .busy_o      (busy),
        .mem_rd_o    (mem_rd),
        .mem_addr_o  (mem_addr),
        .mem_data_i  (mem_data),
        .req_valid_o (req_valid),
        .req_ready_i (req_ready),
        .req_addr_o  (req_addr),
        .req_len_o   (req_len),
        .req_idx_o   (req_idx),
        .req_last_o  (req_last),
        .done_o      (done),
        .frame_len_o (frame_len),
        .err_o       (err),
        .err_code_o  (err_code)
    );

    // Synchronous descriptor memory, one cycle of read latency.
    always @(posedge clk) begin
        if (mem_rd) begin
            mem_data <= {dbytes[4*mem_addr+3], dbytes[4*mem_addr+2],
                         dbytes[4*mem_addr+1], dbytes[4*mem_addr]};
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Lay out the byte image of a descriptor from the expected entry table.
    task automatic build(input logic [7:0] count_byte);
        for (int b = 0; b < 128; b++) dbytes[b] = 8'(b * 29 + 7);
        dbytes[3] = count_byte;
        for (int i = 0; i < NBUF; i++) begin
            int off = 4 + 6 * i;
            dbytes[off]     = exp_addr[i][7:0];
            dbytes[off + 1] = exp_addr[i][15:8];
            dbytes[off + 2] = exp_addr[i][23:16];
            dbytes[off + 3] = exp_addr[i][31:24];
            dbytes[off + 4] = {exp_len[i][3:0], exp_addr[i][35:32]};
            dbytes[off + 5] = exp_len[i][11:4];
        end
    endtask

    task automatic fill_default(input int c);
        for (int i = 0; i < NBUF; i++) begin
            exp_addr[i] = {4'((i + c) & 15), 32'h8000_0000 + 32'(i) * 32'h0101_0103 + 32'(c) * 32'h10};
            exp_len[i]  = 12'((i * 53 + c * 7) % 400 + 1);
        end
    endtask

    task automatic run(input logic [7:0] count_byte, input int mode, input bit poke,
                       input string tag);
        int cnt = int'(count_byte[4:0]);
        int exp_n;
        int exp_code;
        int total = 0;
        int j = 0;
        int last_acc = -10;
        bit finished = 0;
        exp_code = 0;
        exp_n    = cnt;
        if (cnt == 0 || cnt > NBUF) begin
            exp_code = 1;
            exp_n    = 0;
        end else begin
            for (int i = 0; i < cnt; i++) begin
                if (int'(exp_len[i]) > 4092) begin
                    exp_code = 2; exp_n = i; break;
                end
                if (total + int'(exp_len[i]) > 8192) begin
                    exp_code = 3; exp_n = i; break;
                end
                total += int'(exp_len[i]);
            end
        end
        build(count_byte);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 3000 && !finished; cyc++) begin
            case (mode)
                0:       req_ready = 1'b1;
                1:       req_ready = cyc[0];
                default: req_ready = (cyc % 3 == 2);
            endcase
            start = poke && (cyc >= 3 && cyc <= 5);
            #1;
            if (req_valid && req_ready) begin
                bit ok = (j < exp_n) && req_addr == exp_addr[j] && req_len == exp_len[j]
                         && int'(req_idx) == j
                         && req_last == (exp_code == 0 && j == exp_n - 1);
                // R4 decode and ordering, R5 one request per acceptance
                check(ok, {"R4 request ", tag}, {req_addr, req_len, req_idx, req_last},
                      {exp_addr[j], exp_len[j], 5'(j), 1'b0});
                j++;
                last_acc = cyc;
            end
            if (done) begin
                finished = 1;
                check(exp_code == 0, {"R8 done expected ", tag}, 64'(0), 64'(exp_code));
                check(j == exp_n, {"R8 request count ", tag}, 64'(j), 64'(exp_n));
                check(last_acc == cyc - 1, {"R8 done timing ", tag}, 64'(cyc - last_acc), 64'd1);
                check(int'(frame_len) == total, {"R8 frame length ", tag}, 64'(frame_len), 64'(total));
            end
            if (err) begin
                finished = 1;
                // R3 bad count, R6 buffer cap, R7 frame cap
                check(int'(err_code) == exp_code, {"R3/R6/R7 error code ", tag},
                      64'(err_code), 64'(exp_code));
                check(j == exp_n, {"R6 requests before error ", tag}, 64'(j), 64'(exp_n));
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(finished, {"R8 walk finished ", tag}, 64'(finished), 64'd1);
        // R9: idle right after the pulse; R1: pokes while busy started nothing
        #1;
        check(!busy, {"R9 idle after end ", tag}, 64'(busy), 64'd0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #1;
            if (poke) check(!busy && !req_valid, {"R1 start ignored while busy ", tag},
                            64'({busy, req_valid}), 64'd0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        start     = 1'b0;
        req_ready = 1'b0;
        for (int b = 0; b < 128; b++) dbytes[b] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state
        check(!busy && !req_valid && !mem_rd && !done && !err, "R10 reset state",
              64'({busy, req_valid, mem_rd, done, err}), 64'd0);

        // Sweep every count value; R2 padding bits vary with c
        for (int c = 0; c < 32; c++) begin
            fill_default(c);
            run({3'(c * 5), 5'(c)}, c % 3, 1'b0, $sformatf("sweep c=%0d", c));
        end

        // R2: reserved bits of the count byte all set
        fill_default(40);
        run(8'hE3, 1, 1'b0, "R2 reserved bits set");

        // R6/R7 boundaries: 4092 + 4092 + 8 = 8192 exactly
        fill_default(41);
        exp_len[0] = 12'd4092; exp_len[1] = 12'd4092; exp_len[2] = 12'd8;
        exp_addr[1] = 36'hF_FFFF_FFFF;
        run(8'h03, 2, 1'b0, "R7 frame exactly 8192");

        fill_default(42);
        exp_len[1] = 12'd4093;
        run(8'h04, 0, 1'b0, "R6 buffer 4093");

        fill_default(43);
        exp_len[0] = 12'd4095;
        run(8'h05, 1, 1'b0, "R6 first buffer 4095");

        fill_default(44);
        exp_len[0] = 12'd4092; exp_len[1] = 12'd4092; exp_len[2] = 12'd9;
        run(8'h06, 0, 1'b0, "R7 frame 8193");

        fill_default(45);
        exp_len[19] = 12'd0;
        run(8'd20, 2, 1'b1, "R1 start pokes, twenty buffers");

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule